// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Pair

This block collects up to seven interrupt sources into one active-high request line. Each source owns one pending bit. A one-cycle pulse from the source sets the bit. The bit is cleared in one of two ways: software writes a one to that position of the pending register, or another part of the chip sends a one-cycle clear pulse as a side effect of some access. A second register holds one mask bit per source. The request line is high while at least one source is both pending and unmasked.

The mask register is written in set/clear form, so software never needs a read-modify-write. The top data bit of the written byte chooses the action. When it is one, every data bit written as one sets its mask bit. When it is zero, every data bit written as one clears its mask bit. Bits written as zero keep their value in both cases.

A read strobe captures a view of the selected register into a registered read output. The pending view also carries a summary bit in the top position. This bit is computed from the registers and is not stored.

Top module: `irq_flag_enable`

## Requirements
- R1: After reset, all pending bits, all mask bits, both read outputs and `irq_o` are zero.
- R2: A one on bit k of `set_pulse_i` sets pending bit k at the next clock edge. The bit then stays set until it is cleared.
- R3: A write with `sel_i`=0 (pending register) clears every pending bit whose data bit in positions 6:0 is one. Pending bits written as zero are unchanged, and data bit 7 is ignored.
- R4: A one on bit k of `clr_pulse_i` clears pending bit k at the next clock edge.
- R5: If a set pulse and any clear (a clear pulse or a write-clear) reach the same pending bit in the same cycle, the bit ends up set.
- R6: A write with `sel_i`=1 (mask register) and data bit 7 = 1 sets every mask bit whose data bit in positions 6:0 is one. All other mask bits are unchanged.
- R7: A write with `sel_i`=1 and data bit 7 = 0 clears every mask bit whose data bit in positions 6:0 is one. All other mask bits are unchanged.
- R8: `irq_o` is high exactly when the bitwise AND of the pending and mask registers is nonzero. It follows a register update in the same cycle that the register changes, that is, one clock edge after the stimulus.
- R9: A pending-register read returns the pending bits in positions 6:0. Position 7 is one if any unmasked bit is pending.
- R10: A mask-register read returns the mask in positions 6:0 and a constant one in position 7.
- R11: `rd_en_i` high at a clock edge loads the view selected by `sel_i` into `flag_rdata_o` (`sel_i`=0) or `enable_rdata_o` (`sel_i`=1). Each read output holds its value until it is loaded again.
- R12: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register select: 0 = pending register, 1 = mask register |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| set_pulse_i | input | 7 | Per-source set pulses |
| clr_pulse_i | input | 7 | Per-source side-effect clear pulses |
| flag_rdata_o | output | 8 | Registered pending view, with the summary in bit 7 |
| enable_rdata_o | output | 8 | Registered mask view, with bit 7 always one |
| irq_o | output | 1 | Interrupt request |

## Verification
The request logic is driven in three ways, and each separates one kind of fault:
- Pending bits with no matching mask bits. This catches an OR used where an AND is needed.
- Mask bits that are set and then partly cleared through both write encodings. This catches a wrong polarity of the top-bit decode.
- Pending masks that are changed only by clear pulses. This catches a request line that is derived from the wrong register.

The pending register is also hit with set pulses that collide with clear pulses and with write-clears. This shows whether set wins. A write with bit 7 high checks that bit 7 is ignored. Writes to each register are followed by reads of the other, which catches crossed write decodes. Reads are spaced between unrelated stimulus, so that any reload of a read output that should be holding its value shows up as a mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic SEL_FLAG   = 1'b0;
  localparam logic SEL_ENABLE = 1'b1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_pulse,
  input  logic [NUM_SRC-1:0] clr_pulse,
  input  logic               wr_clear,
  input  logic [NUM_SRC-1:0] wr_mask,
  output logic [NUM_SRC-1:0] flag_q
);
  logic [NUM_SRC-1:0] clr_all;

  assign clr_all = clr_pulse | (wr_clear ? wr_mask : '0);

  // One register per source; a set pulse beats any clear in the same cycle.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)               flag_q[b] <= 1'b0;
      else if (set_pulse[b]) flag_q[b] <= 1'b1;
      else if (clr_all[b])   flag_q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               set_mode,
  input  logic [NUM_SRC-1:0] wr_mask,
  output logic [NUM_SRC-1:0] en_q
);
  // The mode bit decides whether the selected ones set or clear mask bits.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                     en_q[b] <= 1'b0;
      else if (wr_en && wr_mask[b]) en_q[b] <= set_mode;
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               sel,
  input  logic [NUM_SRC-1:0] flag_q,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic               summary,
  output logic [DATA_W-1:0]  flag_rdata,
  output logic [DATA_W-1:0]  enable_rdata
);
  import irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_rdata   <= '0;
      enable_rdata <= '0;
    end else if (rd_en) begin
      if (sel == SEL_FLAG) flag_rdata   <= {summary, flag_q};
      else                 enable_rdata <= {1'b1, en_q};
    end
  end
endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable #(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] set_pulse_i,
  input  logic [NUM_SRC-1:0] clr_pulse_i,
  output logic [DATA_W-1:0]  flag_rdata_o,
  output logic [DATA_W-1:0]  enable_rdata_o,
  output logic               irq_o
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;
  logic               wr_flag;
  logic               wr_enable;

  assign wr_flag   = wr_en_i && (sel_i == SEL_FLAG);
  assign wr_enable = wr_en_i && (sel_i == SEL_ENABLE);

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) flag_bank_i (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (set_pulse_i),
    .clr_pulse (clr_pulse_i),
    .wr_clear  (wr_flag),
    .wr_mask   (wdata_i[NUM_SRC-1:0]),
    .flag_q    (flag_q)
  );

  irq_enable_bank #(.NUM_SRC(NUM_SRC)) enable_bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_enable),
    .set_mode (wdata_i[DATA_W-1]),
    .wr_mask  (wdata_i[NUM_SRC-1:0]),
    .en_q     (en_q)
  );

  assign irq_o = |(flag_q & en_q);

  irq_read_port #(.NUM_SRC(NUM_SRC)) read_port_i (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en_i),
    .sel          (sel_i),
    .flag_q       (flag_q),
    .en_q         (en_q),
    .summary      (irq_o),
    .flag_rdata   (flag_rdata_o),
    .enable_rdata (enable_rdata_o)
  );
endmodule

// File: rtl/irq_flag_enable_chk.sv
module irq_flag_enable_chk #(
  parameter int NUM_SRC = 7,
  localparam int DATA_W = NUM_SRC + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               sel_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] set_pulse_i,
  input logic [NUM_SRC-1:0] clr_pulse_i,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [DATA_W-1:0]  flag_rdata_o,
  input logic [DATA_W-1:0]  enable_rdata_o,
  input logic               irq_o
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flag_q == '0 && en_q == '0 && !irq_o));

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    (set_pulse_i != '0) |=> ((flag_q & $past(set_pulse_i)) == $past(set_pulse_i)));

  p_clr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    ((clr_pulse_i & ~set_pulse_i) != '0) |=>
      ((flag_q & $past(clr_pulse_i & ~set_pulse_i)) == '0));

  p_en_set_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel_i && wdata_i[DATA_W-1]) |=>
      ((en_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

  p_en_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel_i && !wdata_i[DATA_W-1]) |=>
      ((en_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

  p_summary_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !sel_i) |=> (flag_rdata_o[DATA_W-1] == $past(irq_o)));

  p_en_view_top_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel_i) |=> enable_rdata_o[DATA_W-1]);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> ($stable(flag_rdata_o) && $stable(enable_rdata_o)));

  p_en_isolated_r12: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && sel_i) |=> $stable(en_q));
endmodule

bind irq_flag_enable irq_flag_enable_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .sel_i          (sel_i),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .wdata_i        (wdata_i),
  .set_pulse_i    (set_pulse_i),
  .clr_pulse_i    (clr_pulse_i),
  .flag_q         (flag_q),
  .en_q           (en_q),
  .flag_rdata_o   (flag_rdata_o),
  .enable_rdata_o (enable_rdata_o),
  .irq_o          (irq_o)
);

// File: tb/irq_flag_enable_tb_top.sv
module irq_flag_enable_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 7;
  localparam int DATA_W = NUM_SRC + 1;

  typedef struct {
    logic              sel;
    logic [DATA_W-1:0] exp;
    string             tag;
  } rd_item_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               sel_i = 1'b0;
  logic               wr_en_i = 1'b0;
  logic               rd_en_i = 1'b0;
  logic [DATA_W-1:0]  wdata_i = '0;
  logic [NUM_SRC-1:0] set_pulse_i = '0;
  logic [NUM_SRC-1:0] clr_pulse_i = '0;
  logic [DATA_W-1:0]  flag_rdata_o;
  logic [DATA_W-1:0]  enable_rdata_o;
  logic               irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  rd_item_t q[$];
  logic [NUM_SRC-1:0] mf = '0;
  logic [NUM_SRC-1:0] me = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_enable #(.NUM_SRC(NUM_SRC)) dut_i (
    .clk(clk), .rst(rst), .sel_i(sel_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wdata_i(wdata_i), .set_pulse_i(set_pulse_i), .clr_pulse_i(clr_pulse_i),
    .flag_rdata_o(flag_rdata_o), .enable_rdata_o(enable_rdata_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One stimulus cycle; the model follows the requirements.
  task automatic cyc(logic [NUM_SRC-1:0] s, logic [NUM_SRC-1:0] c,
                     logic wr, logic sl, logic [DATA_W-1:0] d);
    logic [NUM_SRC-1:0] clr_all;
    set_pulse_i = s; clr_pulse_i = c; wr_en_i = wr; sel_i = sl; wdata_i = d;
    clr_all = c | ((wr && !sl) ? d[NUM_SRC-1:0] : '0);
    mf = (mf & ~clr_all) | s;
    if (wr && sl) me = d[DATA_W-1] ? (me | d[NUM_SRC-1:0]) : (me & ~d[NUM_SRC-1:0]);
    @(negedge clk);
    set_pulse_i = '0; clr_pulse_i = '0; wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic sl, string tag);
    rd_item_t it;
    it.sel = sl;
    it.exp = sl ? {1'b1, me} : {|(mf & me), mf};
    it.tag = tag;
    q.push_back(it);
    rd_en_i = 1'b1; sel_i = sl;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  // Monitor: compares each read result after the edge that loads it.
  always @(posedge clk) begin
    if (rd_en_i && !rst) begin
      #2;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: read result with no expected item");
      end else begin
        rd_item_t it;
        it = q.pop_front();
        check(it.tag, it.sel ? enable_rdata_o : flag_rdata_o, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 flag view", flag_rdata_o, '0);
    check("R1 enable view", enable_rdata_o, '0);
    check("R1 irq", {7'd0, irq_o}, '0);
    rd(1'b0, "R1 pending read");
    rd(1'b1, "R1/R10 mask read");

    cyc(7'h05, '0, 0, 0, '0);
    rd(1'b0, "R2 set pulses");
    check("R8 irq masked", {7'd0, irq_o}, '0);

    cyc('0, '0, 1, 1, 8'h81);
    check("R8 irq after mask set", {7'd0, irq_o}, 8'd1);
    rd(1'b1, "R6 mask set");
    rd(1'b0, "R9 summary high");
    cyc('0, '0, 1, 1, 8'h82);
    rd(1'b1, "R6 zeros unchanged");
    cyc('0, '0, 1, 1, 8'h01);
    check("R8 irq after mask clear", {7'd0, irq_o}, '0);
    rd(1'b1, "R7 mask clear");
    rd(1'b0, "R9 summary low");

    cyc(7'h7A, '0, 0, 0, '0);
    cyc('0, '0, 1, 0, 8'h83);
    rd(1'b0, "R3 write clear bit7 ignored");
    cyc('0, 7'h0C, 0, 0, '0);
    rd(1'b0, "R4 clear pulse");
    cyc(7'h10, 7'h10, 0, 0, '0);
    cyc(7'h01, '0, 1, 0, 8'h01);
    rd(1'b0, "R5 set wins");

    cyc('0, '0, 1, 0, 8'hFF);
    rd(1'b1, "R12 mask kept on pending write");
    cyc(7'h03, '0, 0, 0, '0);
    cyc('0, '0, 1, 1, 8'hFE);
    rd(1'b0, "R12 pending kept on mask write");

    cyc(7'h40, '0, 0, 0, '0);
    check("R8 irq one edge after set", {7'd0, irq_o}, 8'd1);
    cyc('0, 7'h40, 0, 0, '0);
    check("R8 irq one edge after clear", {7'd0, irq_o}, {7'd0, |(mf & me)});

    rd(1'b0, "R11 capture");
    cyc(7'h20, '0, 0, 0, '0);
    check("R11 pending view holds", flag_rdata_o, {1'b1, 7'h03});
    rd(1'b1, "R11 other view");
    check("R11 pending view holds on mask read", flag_rdata_o, {1'b1, 7'h03});

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: %0d reads not observed, expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule